// File: doc/BRIEF.md
# Privileged Trap Entry Dispatcher

This block decides, once per dispatch window, whether the core leaves its current instruction stream for privileged firmware, and where it goes. It watches four asynchronous interrupt sources: device, clock, inter-processor and machine check. It also watches one synchronous exception request port, which carries a kind code and a call number for firmware calls. Each cycle it compares these with the current PC, the privileged-mode flag, the 3-bit interrupt priority level and the firmware base address.

When an entry is taken, the block pulses a redirect strobe together with a privileged-mode set strobe for one cycle. In that same cycle it presents three values:
- the new PC: the firmware base plus an entry-specific offset;
- the saved exception address, whose bit 0 carries the privileged-mode flag;
- for arithmetic traps, the captured exception summary and register mask.

A three-state sequencer controls the timing. In `ST_IDLE` it samples requests. The transition *take* moves it to `ST_ISSUE`, the cycle in which the strobes are high. The transition *retire* moves it to `ST_HOLD`, a settling cycle that gives the surrounding pipeline time to raise the privileged flag. The transition *rearm* returns it to `ST_IDLE`. While in `ST_IDLE` with nothing acceptable, it takes the transition *stay*.

Top module: `trap_dispatch`

## Requirements
- R1: After reset, `redirect_o` and `priv_set_o` are 0, and `trap_sum_o` and `trap_mask_o` are all zeros.
- R2: No interrupt source is taken while `priv_mode_i` is 1. Synchronous exceptions are still taken in that mode.
- R3: The level `ipl_i` admits sources as follows:
  - levels 0 to 3 admit device, clock, inter-processor and machine check;
  - level 4 admits clock, inter-processor and machine check;
  - level 5 admits inter-processor and machine check;
  - level 6 admits machine check only;
  - level 7 admits none.
- R4: Among the admitted sources, machine check wins over inter-processor, inter-processor wins over clock, and clock wins over device.
- R5: For interrupts, firmware calls and illegal operations, `exc_addr_o` equals `cur_pc_i` ORed with `priv_mode_i` in bit 0.
- R6: `new_pc_o` equals `fw_base_i` plus an offset. The fixed offsets are machine check 0x080, inter-processor 0x100, clock 0x180, device 0x200, arithmetic 0x280 and illegal operation 0x300.
- R7: A firmware call (`exc_kind_i` = 2'b01) with a number n from 0x00 to 0x3F enters at offset 0x1000 + 64·n.
- R8: A firmware call with a number n from 0x80 to 0xBF enters at offset 0x2000 + 64·(n − 0x80).
- R9: A firmware call number outside both ranges, `exc_kind_i` = 2'b10, and `exc_kind_i` = 2'b11 all enter as an illegal operation.
- R10: An arithmetic exception (`exc_kind_i` = 2'b00) loads `trap_sum_o` and `trap_mask_o` from `arith_sum_i` and `arith_mask_i`. Its `exc_addr_o` is (`cur_pc_i` + 4) ORed with `priv_mode_i`. No other entry changes `trap_sum_o` or `trap_mask_o`.
- R11: When `exc_valid_i` is 1 in `ST_IDLE`, the synchronous exception is taken even if an admitted interrupt is pending.
- R12: Requests are sampled on a clock edge in `ST_IDLE`. `redirect_o` and `priv_set_o` are then high for exactly the following cycle, and requests present at the next two edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_dev_i | input | 1 | Device interrupt pending |
| req_clk_i | input | 1 | Clock interrupt pending |
| req_ipi_i | input | 1 | Inter-processor interrupt pending |
| req_mchk_i | input | 1 | Machine check pending |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_kind_i | input | 2 | 00 arithmetic, 01 firmware call, 10/11 illegal operation |
| call_num_i | input | 8 | Firmware call number |
| arith_sum_i | input | 7 | Arithmetic exception summary |
| arith_mask_i | input | 64 | Arithmetic destination register mask |
| cur_pc_i | input | 64 | PC of the current instruction |
| priv_mode_i | input | 1 | Core is in privileged firmware mode |
| ipl_i | input | 3 | Current interrupt priority level |
| fw_base_i | input | 64 | Firmware base address |
| redirect_o | output | 1 | One-cycle redirect strobe |
| new_pc_o | output | 64 | Firmware entry address |
| exc_addr_o | output | 64 | Saved return address with mode bit |
| priv_set_o | output | 1 | Strobe to enter privileged mode |
| trap_sum_o | output | 7 | Last captured arithmetic summary |
| trap_mask_o | output | 64 | Last captured arithmetic register mask |

## Verification
Several rules are checked by the assertions on every cycle:
- the single-cycle strobe;
- the absence of any redirect at level 7 or in privileged mode without a synchronous request;
- the mode bit in the saved address;
- the one-hot grant;
- capture of the arithmetic operands;
- 64-byte alignment of every entry offset.

Only the bench's scenarios can show that each source, level and call number reaches the exact entry address. The same applies to the priority order when several sources are pending, to synchronous precedence over a pending machine check, and to requests held across the issue and hold cycles producing only one entry.

// File: rtl/trap_dispatch_pkg.sv
package trap_dispatch_pkg;

    typedef enum logic [1:0] {
        EXC_ARITH   = 2'b00,
        EXC_CALL    = 2'b01,
        EXC_ILLEGAL = 2'b10,
        EXC_RSVD    = 2'b11
    } exc_kind_e;

    typedef enum logic [2:0] {
        ENT_NONE,
        ENT_MCHK,
        ENT_IPI,
        ENT_CLK,
        ENT_DEV,
        ENT_ARITH,
        ENT_ILLEGAL,
        ENT_CALL
    } entry_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_HOLD
    } state_e;

    localparam int ENTRY_OFF_W = 16;

    localparam logic [ENTRY_OFF_W-1:0] OFF_MCHK    = 16'h0080;
    localparam logic [ENTRY_OFF_W-1:0] OFF_IPI     = 16'h0100;
    localparam logic [ENTRY_OFF_W-1:0] OFF_CLK     = 16'h0180;
    localparam logic [ENTRY_OFF_W-1:0] OFF_DEV     = 16'h0200;
    localparam logic [ENTRY_OFF_W-1:0] OFF_ARITH   = 16'h0280;
    localparam logic [ENTRY_OFF_W-1:0] OFF_ILLEGAL = 16'h0300;

    localparam logic [ENTRY_OFF_W-1:0] OFF_PRIV_CALLS   = 16'h1000;
    localparam logic [ENTRY_OFF_W-1:0] OFF_UNPRIV_CALLS = 16'h2000;

endpackage

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter #(
    parameter int LVL_W = 3,
    parameter int NSRC  = 4,
    parameter logic [NSRC*LVL_W-1:0] MAX_LVL = {3'd6, 3'd5, 3'd4, 3'd3}
) (
    input  logic [NSRC-1:0]  req_i,
    input  logic [LVL_W-1:0] ipl_i,
    input  logic             block_i,
    output logic [NSRC-1:0]  grant_o,
    output logic             any_o
);

    logic [NSRC-1:0] admit;

    // Source g may interrupt while the level is at or below its ceiling.
    for (genvar g = 0; g < NSRC; g++) begin : g_admit
        assign admit[g] = req_i[g] && !block_i && (ipl_i <= MAX_LVL[g*LVL_W +: LVL_W]);
    end

    // Highest index wins.
    always_comb begin
        logic higher;
        higher  = 1'b0;
        grant_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            grant_o[i] = admit[i] && !higher;
            higher     = higher | admit[i];
        end
    end

    assign any_o = |admit;

    always_comb begin
        assert_grant_onehot_R4: assert ($onehot0(grant_o))
            else $error("grant vector has more than one bit set");
        assert_grant_any_R4: assert ((grant_o != '0) == any_o)
            else $error("grant and any flag disagree");
    end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
    import trap_dispatch_pkg::*;
#(
    parameter int CALL_W     = 8,
    parameter int CALLS      = 64,
    parameter int SLOT_BYTES = 64,
    parameter int UNPRIV_BIT = 7
) (
    input  entry_e                  entry_i,
    input  logic [CALL_W-1:0]       call_i,
    output logic [ENTRY_OFF_W-1:0]  offset_o
);

    localparam int IDX_W   = $clog2(CALLS);
    localparam int SLOT_SH = $clog2(SLOT_BYTES);
    localparam int HI_W    = CALL_W - IDX_W;
    localparam logic [HI_W-1:0] UNPRIV_TAG = HI_W'(1) << (UNPRIV_BIT - IDX_W);

    logic [HI_W-1:0]        hi;
    logic [IDX_W-1:0]       idx;
    logic [ENTRY_OFF_W-1:0] slot;
    logic                   is_priv;
    logic                   is_unpriv;

    assign hi        = call_i[CALL_W-1:IDX_W];
    assign idx       = call_i[IDX_W-1:0];
    assign slot      = ENTRY_OFF_W'(idx) << SLOT_SH;
    assign is_priv   = (hi == '0);
    assign is_unpriv = (hi == UNPRIV_TAG);

    always_comb begin
        unique case (entry_i)
            ENT_MCHK:    offset_o = OFF_MCHK;
            ENT_IPI:     offset_o = OFF_IPI;
            ENT_CLK:     offset_o = OFF_CLK;
            ENT_DEV:     offset_o = OFF_DEV;
            ENT_ARITH:   offset_o = OFF_ARITH;
            ENT_CALL: begin
                if (is_priv)        offset_o = OFF_PRIV_CALLS + slot;
                else if (is_unpriv) offset_o = OFF_UNPRIV_CALLS + slot;
                else                offset_o = OFF_ILLEGAL;
            end
            default:     offset_o = OFF_ILLEGAL;
        endcase
    end

    always_comb begin
        assert_slot_aligned_R8: assert (offset_o[SLOT_SH-1:0] == '0)
            else $error("entry offset not aligned to slot size");
    end

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import trap_dispatch_pkg::*;
#(
    parameter int PC_W       = 64,
    parameter int LVL_W      = 3,
    parameter int CALL_W     = 8,
    parameter int SUM_W      = 7,
    parameter int MASK_W     = 64,
    parameter int INSN_BYTES = 4,
    parameter int DEV_MAX    = 3,
    parameter int CLK_MAX    = 4,
    parameter int IPI_MAX    = 5,
    parameter int MCHK_MAX   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_dev_i,
    input  logic              req_clk_i,
    input  logic              req_ipi_i,
    input  logic              req_mchk_i,
    input  logic              exc_valid_i,
    input  logic [1:0]        exc_kind_i,
    input  logic [CALL_W-1:0] call_num_i,
    input  logic [SUM_W-1:0]  arith_sum_i,
    input  logic [MASK_W-1:0] arith_mask_i,
    input  logic [PC_W-1:0]   cur_pc_i,
    input  logic              priv_mode_i,
    input  logic [LVL_W-1:0]  ipl_i,
    input  logic [PC_W-1:0]   fw_base_i,
    output logic              redirect_o,
    output logic [PC_W-1:0]   new_pc_o,
    output logic [PC_W-1:0]   exc_addr_o,
    output logic              priv_set_o,
    output logic [SUM_W-1:0]  trap_sum_o,
    output logic [MASK_W-1:0] trap_mask_o
);

    localparam int NSRC = 4;
    localparam logic [NSRC*LVL_W-1:0] LVL_CEIL =
        {LVL_W'(MCHK_MAX), LVL_W'(IPI_MAX), LVL_W'(CLK_MAX), LVL_W'(DEV_MAX)};

    state_e                 state_q, state_d;
    entry_e                 entry;
    logic [NSRC-1:0]        req_vec;
    logic [NSRC-1:0]        grant;
    logic                   irq_any;
    logic                   take;
    logic [ENTRY_OFF_W-1:0] offset;
    logic [PC_W-1:0]        ret_pc;
    exc_kind_e              kind;

    assign req_vec = {req_mchk_i, req_ipi_i, req_clk_i, req_dev_i};
    assign kind    = exc_kind_e'(exc_kind_i);

    trap_irq_arbiter #(
        .LVL_W   (LVL_W),
        .NSRC    (NSRC),
        .MAX_LVL (LVL_CEIL)
    ) u_arb (
        .req_i   (req_vec),
        .ipl_i   (ipl_i),
        .block_i (priv_mode_i),
        .grant_o (grant),
        .any_o   (irq_any)
    );

    // Synchronous requests take precedence over interrupts.
    always_comb begin
        if (exc_valid_i) begin
            unique case (kind)
                EXC_ARITH: entry = ENT_ARITH;
                EXC_CALL:  entry = ENT_CALL;
                default:   entry = ENT_ILLEGAL;
            endcase
        end else if (irq_any) begin
            if (grant[3])      entry = ENT_MCHK;
            else if (grant[2]) entry = ENT_IPI;
            else if (grant[1]) entry = ENT_CLK;
            else               entry = ENT_DEV;
        end else begin
            entry = ENT_NONE;
        end
    end

    trap_vector_gen #(
        .CALL_W     (CALL_W),
        .CALLS      (64),
        .SLOT_BYTES (64),
        .UNPRIV_BIT (7)
    ) u_vec (
        .entry_i  (entry),
        .call_i   (call_num_i),
        .offset_o (offset)
    );

    assign take   = (state_q == ST_IDLE) && (entry != ENT_NONE);
    assign ret_pc = (entry == ENT_ARITH) ? cur_pc_i + PC_W'(INSN_BYTES) : cur_pc_i;

    // Next-state logic: take, retire, rearm, stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = take ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o  <= 1'b0;
            priv_set_o  <= 1'b0;
            new_pc_o    <= '0;
            exc_addr_o  <= '0;
            trap_sum_o  <= '0;
            trap_mask_o <= '0;
        end else begin
            redirect_o <= take;
            priv_set_o <= take;
            if (take) begin
                new_pc_o   <= fw_base_i + PC_W'(offset);
                exc_addr_o <= ret_pc | PC_W'(priv_mode_i);
                if (entry == ENT_ARITH) begin
                    trap_sum_o  <= arith_sum_i;
                    trap_mask_o <= arith_mask_i;
                end
            end
        end
    end

    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o)
        else $error("redirect strobe longer than one cycle");

    assert_priv_blocks_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && priv_mode_i && !exc_valid_i) |=> !redirect_o)
        else $error("interrupt taken in privileged mode");

    assert_top_level_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !exc_valid_i && ipl_i == '1) |=> !redirect_o)
        else $error("interrupt taken at highest level");

    assert_mode_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && $past(priv_mode_i)) |-> exc_addr_o[0])
        else $error("saved address lost mode bit");

    assert_sync_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && exc_valid_i) |=> redirect_o)
        else $error("synchronous exception not taken");

    assert_arith_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && exc_valid_i && exc_kind_i == 2'b00)
            |=> (trap_mask_o == $past(arith_mask_i) && trap_sum_o == $past(arith_sum_i)))
        else $error("arithmetic operands not captured");

endmodule

// File: tb/trap_dispatch_bench.sv
`timescale 1ns/1ps
module trap_dispatch_bench;

    localparam logic [63:0] FW = 64'h0000_0001_0000_0000;

    typedef struct {
        logic [63:0] pc;
        logic [63:0] addr;
        logic [6:0]  sum;
        logic [63:0] mask;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_dev = 0, req_clk = 0, req_ipi = 0, req_mchk = 0;
    logic        exc_valid = 0;
    logic [1:0]  exc_kind = 0;
    logic [7:0]  call_num = 0;
    logic [6:0]  arith_sum = 0;
    logic [63:0] arith_mask = 0;
    logic [63:0] cur_pc = 0;
    logic        priv_mode = 0;
    logic [2:0]  ipl = 0;
    logic [63:0] fw_base = FW;
    logic        redirect, priv_set;
    logic [63:0] new_pc, exc_addr, trap_mask;
    logic [6:0]  trap_sum;

    int   n_checks = 0;
    int   n_fail = 0;
    int   n_redirect = 0;
    logic [6:0]  m_sum = 0;
    logic [63:0] m_mask = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    trap_dispatch u_trap_dispatch (
        .clk(clk), .rst_n(rst_n),
        .req_dev_i(req_dev), .req_clk_i(req_clk), .req_ipi_i(req_ipi), .req_mchk_i(req_mchk),
        .exc_valid_i(exc_valid), .exc_kind_i(exc_kind), .call_num_i(call_num),
        .arith_sum_i(arith_sum), .arith_mask_i(arith_mask), .cur_pc_i(cur_pc),
        .priv_mode_i(priv_mode), .ipl_i(ipl), .fw_base_i(fw_base),
        .redirect_o(redirect), .new_pc_o(new_pc), .exc_addr_o(exc_addr),
        .priv_set_o(priv_set), .trap_sum_o(trap_sum), .trap_mask_o(trap_mask)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        {req_dev, req_clk, req_ipi, req_mchk} = 4'b0;
        exc_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per observed redirect.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && redirect) begin
                n_redirect++;
                if (q.size() == 0) begin
                    chk(1'b0, "R12 unexpected redirect", new_pc, 64'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(new_pc == e.pc, {e.tag, " new_pc"}, new_pc, e.pc);
                    chk(exc_addr == e.addr, {e.tag, " exc_addr"}, exc_addr, e.addr);
                    chk(priv_set == 1'b1, "R12 priv_set strobe", 64'(priv_set), 64'h1);
                    chk(trap_sum == e.sum && trap_mask == e.mask, {e.tag, " R10 trap regs"},
                        trap_mask ^ 64'(trap_sum), e.mask ^ 64'(e.sum));
                end
            end
        end
    end

    // Driver: inputs set by the caller at a falling edge.
    task automatic expect_take(input logic [63:0] off, input logic [63:0] addr,
                               input int extra_hold, input string tag);
        exp_t e;
        e.pc = FW + off; e.addr = addr; e.sum = m_sum; e.mask = m_mask; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        if (extra_hold == 0) clear_all();
        @(negedge clk);
        chk(redirect == 1'b0, "R12 strobe one cycle", 64'(redirect), 64'h0);
        if (extra_hold == 1) clear_all();
        @(negedge clk);
        if (extra_hold == 2) clear_all();
    endtask

    task automatic expect_none(input string tag);
        int c;
        c = n_redirect;
        @(negedge clk);
        clear_all();
        @(negedge clk);
        chk(n_redirect == c, tag, 64'(n_redirect), 64'(c));
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog expired", 64'h0, 64'h1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(redirect == 0 && priv_set == 0, "R1 strobes in reset", 64'({redirect, priv_set}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trap_sum == 0 && trap_mask == 0, "R1 trap regs after reset", trap_mask, 64'h0);
        chk(redirect == 0, "R1 no redirect after reset", 64'(redirect), 64'h0);

        // Level masking and single sources (R3, R5, R6)
        cur_pc = 64'h1000; ipl = 0; req_dev = 1;
        expect_take(64'h200, 64'h1000, 0, "R3 R5 R6 device at level 0");
        ipl = 4; req_dev = 1;
        expect_none("R3 device masked at level 4");
        ipl = 4; req_clk = 1;
        expect_take(64'h180, 64'h1000, 0, "R3 R6 clock at level 4");
        ipl = 5; req_clk = 1;
        expect_none("R3 clock masked at level 5");
        ipl = 6; req_ipi = 1;
        expect_none("R3 ipi masked at level 6");
        ipl = 6; {req_dev, req_clk, req_ipi, req_mchk} = 4'hF;
        expect_take(64'h080, 64'h1000, 0, "R3 machine check at level 6");
        ipl = 7; req_mchk = 1;
        expect_none("R3 level 7 blocks all");

        // Priority (R4)
        ipl = 0; {req_dev, req_clk, req_ipi, req_mchk} = 4'hF;
        expect_take(64'h080, 64'h1000, 0, "R4 machine check first");
        {req_dev, req_clk, req_ipi} = 3'b111;
        expect_take(64'h100, 64'h1000, 0, "R4 ipi over clock and device");
        {req_dev, req_clk} = 2'b11;
        expect_take(64'h180, 64'h1000, 0, "R4 clock over device");

        // Privileged mode (R2) and firmware calls (R5, R7)
        priv_mode = 1; cur_pc = 64'h2008; req_dev = 1;
        expect_none("R2 interrupt blocked in privileged mode");
        exc_valid = 1; exc_kind = 2'b01; call_num = 8'h05;
        expect_take(64'h1140, 64'h2009, 0, "R2 R5 R7 call 0x05 in privileged mode");
        priv_mode = 0; cur_pc = 64'h3000;
        exc_valid = 1; exc_kind = 2'b01; call_num = 8'h3F;
        expect_take(64'h1FC0, 64'h3000, 0, "R7 call 0x3F");
        exc_valid = 1; exc_kind = 2'b01; call_num = 8'h80;
        expect_take(64'h2000, 64'h3000, 0, "R8 call 0x80");
        exc_valid = 1; exc_kind = 2'b01; call_num = 8'hBF;
        expect_take(64'h2FC0, 64'h3000, 0, "R8 call 0xBF");

        // Illegal numbers and kinds (R9)
        exc_valid = 1; exc_kind = 2'b01; call_num = 8'h40;
        expect_take(64'h300, 64'h3000, 0, "R9 call 0x40 illegal");
        exc_valid = 1; exc_kind = 2'b01; call_num = 8'hC0;
        expect_take(64'h300, 64'h3000, 0, "R9 call 0xC0 illegal");
        exc_valid = 1; exc_kind = 2'b11;
        expect_take(64'h300, 64'h3000, 0, "R9 reserved kind illegal");

        // Arithmetic trap (R10)
        cur_pc = 64'h4000; arith_sum = 7'h15; arith_mask = 64'h0000_00F0_0000_0003;
        m_sum = 7'h15; m_mask = 64'h0000_00F0_0000_0003;
        exc_valid = 1; exc_kind = 2'b00;
        expect_take(64'h280, 64'h4004, 0, "R10 arithmetic entry");
        arith_sum = 7'h2A; arith_mask = 64'hFFFF;
        exc_valid = 1; exc_kind = 2'b10;
        expect_take(64'h300, 64'h4000, 0, "R10 illegal keeps trap regs");

        // Sync precedence (R11)
        ipl = 0; req_mchk = 1; exc_valid = 1; exc_kind = 2'b01; call_num = 8'h02;
        expect_take(64'h1080, 64'h4000, 0, "R11 call over machine check");

        // Held request across issue and hold cycles (R12)
        begin
            int c0;
            c0 = n_redirect;
            req_dev = 1;
            expect_take(64'h200, 64'h4000, 2, "R12 held device request");
            @(negedge clk);
            @(negedge clk);
            chk(n_redirect == c0 + 1, "R12 single entry for held request", 64'(n_redirect), 64'(c0 + 1));
        end

        chk(q.size() == 0, "R12 all expected entries seen", 64'(q.size()), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule